// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on one output line. The frames carry 5 to 9 data bits, an optional even or odd parity bit, and one or two stop bits. A one-entry holding register sits in front of the frame shifter. Software can therefore queue the next character while the current one is still going out. The queued character moves into the shifter at the very tick that ends the last stop bit, so consecutive frames leave no idle gap between them. Bit timing comes from a one-cycle baud tick supplied by an external divider, and every bit lasts one tick period.

The configuration register holds the following settings:
- the enable;
- the ninth data bit;
- the two interrupt enables;
- the data length;
- the parity mode;
- the stop-bit count.

A separate data strobe writes the low byte. The block reports whether the holding register is empty and whether the last frame has finished. It raises level interrupt requests for both conditions. It also outputs a flag that says whether it currently owns the line. When the enable is cleared, the block keeps this ownership until every queued bit has left.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A frame starts with one low start bit, then the data bits least significant first, then the stop bits, which are high. The start bit begins on a baud tick, and every bit lasts exactly one baud tick period.
- R2: The data length is set by `cfg_len`, which gives the bit count directly. Values below 5 act as 5 and values above 9 act as 9. Written bits above the selected length are not transmitted and do not enter the parity.
- R3: The ninth data bit is taken from the configured `cfg_bit9` value at the moment the data write is accepted. A later change of `cfg_bit9` does not alter a character that is already queued.
- R4: `cfg_par` selects the parity: 2'b10 is even, 2'b11 is odd, and 2'b0x is none. The parity bit covers the transmitted data bits and is sent between the last data bit and the first stop bit.
- R5: With `cfg_stop2` = 1 the frame ends with two stop bits; otherwise it ends with one.
- R6: `empty_flag` is high whenever no character is waiting in the holding register. An accepted write lowers it in the following cycle. The waiting character is loaded on a baud tick when the shifter is idle, or on the tick that ends the previous frame's last stop bit, in which case no idle bit appears between the frames.
- R7: A data write while `empty_flag` is low is ignored. The waiting character is kept and the dropped value is never sent.
- R8: `empty_irq` equals `empty_flag` AND the empty interrupt enable, as a level.
- R9: `done_flag` rises when the last stop bit of a frame ends and no character is waiting. It then stays high until it is cleared.
- R10: `done_flag` is cleared by a pulse on `done_clr` (write-one-to-clear) or on `done_ack` (interrupt acknowledge). `done_irq` equals `done_flag` AND the done interrupt enable.
- R11: After the enable is cleared, `line_owned` stays high until both the shifter and the holding register are empty. Data writes made while `line_owned` is low are ignored.
- R12: After reset, and whenever no frame is being sent, `txd` is high. Reset gives `empty_flag` = 1, `done_flag` = 0, `line_owned` = 0 and both interrupt requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-period strobe from the external divider |
| cfg_wr | input | 1 | Loads all configuration fields below |
| cfg_en | input | 1 | Transmit enable |
| cfg_bit9 | input | 1 | Ninth data bit for the next data write |
| cfg_empty_ie | input | 1 | Empty interrupt enable |
| cfg_done_ie | input | 1 | Done interrupt enable |
| cfg_len | input | LEN_W | Data bit count (clamped to 5..9) |
| cfg_par | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| data_wr | input | 1 | Data write strobe |
| data_in | input | BYTE_W | Low data byte |
| done_clr | input | 1 | Write-one clear of the done flag |
| done_ack | input | 1 | Done interrupt acknowledge, clears the flag |
| txd | output | 1 | Serial output line, high when idle |
| line_owned | output | 1 | Block currently drives the line |
| empty_flag | output | 1 | Holding register empty |
| done_flag | output | 1 | Transmission complete |
| empty_irq | output | 1 | Level interrupt request for empty |
| done_irq | output | 1 | Level interrupt request for done |

## Verification
The bench builds the block with its defaults: BYTE_W = 8, PARITY_EN = 1 and MAX_STOP = 2. These keep the parity generator in the design, bring the ninth bit within reach, and allow the two-stop-bit frame. With them, one run covers the longest frame: start bit, 9 data bits, parity and 2 stop bits. It also covers both clamp directions of the length field and the shortest 5-bit frame with upper bits set. Back-to-back hand-over, dropped writes while the register is full, and the deferred release of the line are exercised on the same build.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

   typedef enum logic [1:0] {
      PAR_OFF     = 2'b00,
      PAR_OFF_ALT = 2'b01,
      PAR_EVEN    = 2'b10,
      PAR_ODD     = 2'b11
   } par_mode_e;

   localparam int unsigned MIN_DATA_BITS = 5;

   function automatic int clamp_len(input int raw, input int lo, input int hi);
      if (raw < lo)      return lo;
      else if (raw > hi) return hi;
      else               return raw;
   endfunction

endpackage

// File: rtl/uatx_holdbuf.sv
module uatx_holdbuf #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          wr_ok,
   input  logic [DW-1:0] wr_data,
   input  logic          take,
   output logic          valid,
   output logic [DW-1:0] data
);

   logic          valid_q;
   logic [DW-1:0] data_q;
   logic          accept;

   assign accept = wr_req && wr_ok && !valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (accept) begin
         valid_q <= 1'b1;
         data_q  <= wr_data;
      end else if (take) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;

   // R6: the shifter only draws a character that is actually waiting
   assert_take_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> valid_q);

   // R7: a full register keeps its content whatever is written
   assert_keep_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !take) |=> (valid_q && $stable(data_q)));

endmodule

// File: rtl/uatx_framer.sv
module uatx_framer
   import uatx_pkg::*;
#(
   parameter int  DATA_MAX  = 9,
   parameter int  MAX_STOP  = 2,
   parameter bit  PARITY_EN = 1'b1,
   parameter int  LEN_W     = 4,
   parameter int  FRAME_W   = 12,
   parameter int  REM_W     = 4
) (
   input  logic [DATA_MAX-1:0] data,
   input  logic [LEN_W-1:0]    len_raw,
   input  logic [1:0]          par,
   input  logic                stop2,
   output logic [FRAME_W-1:0]  frame,
   output logic [REM_W-1:0]    nbits
);

   int                  n;
   int                  stops;
   logic [DATA_MAX-1:0] dm;
   logic                par_on;
   logic                pbit;

   always_comb begin
      n = clamp_len(int'(len_raw), int'(MIN_DATA_BITS), DATA_MAX);
      for (int i = 0; i < DATA_MAX; i++) begin
         dm[i] = (i < n) ? data[i] : 1'b0;
      end
   end

   generate
      if (PARITY_EN) begin : g_par
         assign par_on = (par == PAR_EVEN) || (par == PAR_ODD);
         assign pbit   = (^dm) ^ (par == PAR_ODD);
      end else begin : g_nopar
         assign par_on = 1'b0;
         assign pbit   = 1'b0;
      end
   endgenerate

   always_comb begin
      frame = '1;
      for (int i = 0; i < FRAME_W; i++) begin
         if (i < DATA_MAX && i < n) frame[i] = dm[i];
         else if (par_on && i == n)  frame[i] = pbit;
      end
      stops = (stop2 && MAX_STOP > 1) ? 2 : 1;
      nbits = REM_W'(n + (par_on ? 1 : 0) + stops);
   end

endmodule

// File: rtl/uatx_serializer.sv
module uatx_serializer #(
   parameter int FRAME_W = 12,
   parameter int REM_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               hold_valid,
   input  logic [FRAME_W-1:0] frame,
   input  logic [REM_W-1:0]   nbits,
   output logic               take,
   output logic               busy,
   output logic               txd,
   output logic               frame_end
);

   logic               busy_q;
   logic               txd_q;
   logic [REM_W-1:0]   rem_q;
   logic [FRAME_W-1:0] sh_q;
   logic               last;

   assign last      = busy_q && (rem_q == '0);
   assign frame_end = baud_tick && last;
   assign take      = baud_tick && hold_valid && (!busy_q || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
         rem_q  <= '0;
         sh_q   <= '1;
      end else if (take) begin
         busy_q <= 1'b1;
         txd_q  <= 1'b0;
         sh_q   <= frame;
         rem_q  <= nbits;
      end else if (frame_end) begin
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
      end else if (baud_tick && busy_q) begin
         txd_q  <= sh_q[0];
         sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
         rem_q  <= rem_q - 1'b1;
      end
   end

   assign busy = busy_q;
   assign txd  = txd_q;

   // R1: every load puts a low start bit on the line
   assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!txd_q && busy_q));

   // R12: the line rests high whenever no frame is in flight
   assert_idle_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> txd_q);

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
   parameter int BYTE_W    = 8,
   parameter bit PARITY_EN = 1'b1,
   parameter int MAX_STOP  = 2,
   parameter int LEN_W     = $clog2(BYTE_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_wr,
   input  logic              cfg_en,
   input  logic              cfg_bit9,
   input  logic              cfg_empty_ie,
   input  logic              cfg_done_ie,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_stop2,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] data_in,
   input  logic              done_clr,
   input  logic              done_ack,
   output logic              txd,
   output logic              line_owned,
   output logic              empty_flag,
   output logic              done_flag,
   output logic              empty_irq,
   output logic              done_irq
);

   localparam int DATA_MAX = BYTE_W + 1;
   localparam int FRAME_W  = DATA_MAX + 1 + MAX_STOP;
   localparam int REM_W    = $clog2(FRAME_W + 1);

   generate
      if (BYTE_W < 5 || BYTE_W > 12) begin : g_bad_width
         $error("dbuf_uart_tx: BYTE_W must lie in 5..12");
      end
      if (MAX_STOP < 1 || MAX_STOP > 2) begin : g_bad_stop
         $error("dbuf_uart_tx: MAX_STOP must be 1 or 2");
      end
      if ((1 << LEN_W) <= DATA_MAX) begin : g_bad_len
         $error("dbuf_uart_tx: LEN_W too narrow for the data length");
      end
   endgenerate

   // configuration register
   logic             en_q, bit9_q, eie_q, die_q, stop2_q;
   logic [LEN_W-1:0] len_q;
   logic [1:0]       par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         bit9_q  <= 1'b0;
         eie_q   <= 1'b0;
         die_q   <= 1'b0;
         stop2_q <= 1'b0;
         len_q   <= LEN_W'(BYTE_W);
         par_q   <= 2'b00;
      end else if (cfg_wr) begin
         en_q    <= cfg_en;
         bit9_q  <= cfg_bit9;
         eie_q   <= cfg_empty_ie;
         die_q   <= cfg_done_ie;
         stop2_q <= cfg_stop2;
         len_q   <= cfg_len;
         par_q   <= cfg_par;
      end
   end

   logic                hold_valid;
   logic [DATA_MAX-1:0] hold_data;
   logic                take;
   logic                busy;
   logic                frame_end;
   logic [FRAME_W-1:0]  frame;
   logic [REM_W-1:0]    nbits;
   logic                owned;

   assign owned = en_q || busy || hold_valid;

   uatx_holdbuf #(.DW(DATA_MAX)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (data_wr),
      .wr_ok   (owned),
      .wr_data ({bit9_q, data_in}),
      .take    (take),
      .valid   (hold_valid),
      .data    (hold_data)
   );

   uatx_framer #(
      .DATA_MAX (DATA_MAX),
      .MAX_STOP (MAX_STOP),
      .PARITY_EN(PARITY_EN),
      .LEN_W    (LEN_W),
      .FRAME_W  (FRAME_W),
      .REM_W    (REM_W)
   ) u_framer (
      .data    (hold_data),
      .len_raw (len_q),
      .par     (par_q),
      .stop2   (stop2_q),
      .frame   (frame),
      .nbits   (nbits)
   );

   uatx_serializer #(.FRAME_W(FRAME_W), .REM_W(REM_W)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .hold_valid (hold_valid),
      .frame      (frame),
      .nbits      (nbits),
      .take       (take),
      .busy       (busy),
      .txd        (txd),
      .frame_end  (frame_end)
   );

   // completion flag: set wins over a simultaneous clear
   logic done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   done_q <= 1'b0;
      else if (frame_end && !take)  done_q <= 1'b1;
      else if (done_clr || done_ack) done_q <= 1'b0;
   end

   assign line_owned = owned;
   assign empty_flag = !hold_valid;
   assign done_flag  = done_q;
   assign empty_irq  = !hold_valid && eie_q;
   assign done_irq   = done_q && die_q;

   // R9: a frame ending with nothing queued marks completion
   assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !hold_valid) |=> done_q);

   // R10: a clear pulse without a competing set drops the flag
   assert_done_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_clr || done_ack) && !frame_end) |=> !done_q);

   // R11: a released line is always at the idle level
   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !line_owned |-> txd);

endmodule

// File: tb/sim_dbuf_uart_tx.sv
`timescale 1ns/1ps
module sim_dbuf_uart_tx;

   localparam int TICK_DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       cfg_wr = 1'b0, cfg_en = 1'b0, cfg_bit9 = 1'b0;
   logic       cfg_empty_ie = 1'b0, cfg_done_ie = 1'b0, cfg_stop2 = 1'b0;
   logic [3:0] cfg_len = 4'd8;
   logic [1:0] cfg_par = 2'b00;
   logic       data_wr = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic       done_clr = 1'b0, done_ack = 1'b0;
   logic       txd, line_owned, empty_flag, done_flag, empty_irq, done_irq;

   always #4 clk = ~clk;   // 125 MHz

   dbuf_uart_tx u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_bit9(cfg_bit9),
      .cfg_empty_ie(cfg_empty_ie), .cfg_done_ie(cfg_done_ie),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
      .data_wr(data_wr), .data_in(data_in),
      .done_clr(done_clr), .done_ack(done_ack),
      .txd(txd), .line_owned(line_owned), .empty_flag(empty_flag),
      .done_flag(done_flag), .empty_irq(empty_irq), .done_irq(done_irq)
   );

   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   typedef struct {
      logic [15:0] bits;
      int          len;
      bit          gap0;
      string       tag;
   } frame_t;

   frame_t sb[$];

   // expected frame, built from the requirements
   function automatic frame_t mk(input logic [8:0] d, input int len_cfg, input logic [1:0] par,
                                 input bit s2, input bit gap0, input string tag);
      frame_t f;
      int n, k;
      logic p;
      n = (len_cfg < 5) ? 5 : (len_cfg > 9) ? 9 : len_cfg;
      f.bits = '1;
      f.bits[0] = 1'b0;
      p = 1'b0;
      for (int i = 0; i < n; i++) begin
         f.bits[1+i] = d[i];
         p = p ^ d[i];
      end
      k = 1 + n;
      if (par[1]) begin
         f.bits[k] = par[0] ? ~p : p;
         k++;
      end
      k = k + (s2 ? 2 : 1);
      f.len = k;
      f.gap0 = gap0;
      f.tag = tag;
      return f;
   endfunction

   // monitor + baud tick source, both on the falling edge
   int          tick_cnt = 0;
   bit          in_frame = 1'b0;
   int          idx = 0;
   int          gap_cnt = 1000;
   logic [15:0] got;
   frame_t      cur;

   always @(negedge clk) begin
      if (rst_n && baud_tick) begin
         if (!in_frame) begin
            if (txd == 1'b0) begin
               if (sb.size() == 0) begin
                  chk(1'b0, "R7/R11 unexpected frame", 32'd1, 32'd0);
               end else begin
                  cur = sb.pop_front();
                  if (cur.gap0) chk(gap_cnt == 0, "R6 back-to-back gap", gap_cnt, 0);
                  got = '1;
                  got[0] = 1'b0;
                  idx = 1;
                  in_frame = 1'b1;
               end
            end else begin
               gap_cnt++;
            end
         end else begin
            got[idx] = txd;
            idx++;
            if (idx == cur.len) begin
               chk(got == cur.bits, cur.tag, {16'h0, got}, {16'h0, cur.bits});
               in_frame = 1'b0;
               gap_cnt = 0;
            end
         end
      end
      tick_cnt = (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
      baud_tick = (tick_cnt == 0);
   end

   task automatic cfg(input bit en, input bit b9, input bit eie, input bit die,
                      input int len, input logic [1:0] par, input bit s2);
      cfg_wr = 1'b1; cfg_en = en; cfg_bit9 = b9; cfg_empty_ie = eie; cfg_done_ie = die;
      cfg_len = 4'(len); cfg_par = par; cfg_stop2 = s2;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wr(input logic [7:0] b);
      data_wr = 1'b1; data_in = b;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_flag && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_empty();
      int n = 0;
      while (!empty_flag && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic pulse_clr(input bit use_ack);
      if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
      @(negedge clk);
      done_ack = 1'b0; done_clr = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk(txd == 1'b1, "R12 reset txd", txd, 1);
      chk(empty_flag == 1'b1, "R12 reset empty_flag", empty_flag, 1);
      chk(done_flag == 1'b0, "R12 reset done_flag", done_flag, 0);
      chk(line_owned == 1'b0, "R12 reset line_owned", line_owned, 0);
      chk({empty_irq, done_irq} == 2'b00, "R12 reset irqs", {empty_irq, done_irq}, 0);

      // R11 write while not owning the line is dropped
      wr(8'h55);
      chk(empty_flag == 1'b1, "R11 write while disabled", empty_flag, 1);
      repeat (40) @(negedge clk);
      chk(txd == 1'b1, "R12 idle line high", txd, 1);

      cfg(1, 0, 1, 1, 8, 2'b00, 0);
      chk(line_owned == 1'b1, "R11 owned after enable", line_owned, 1);
      chk(empty_irq == 1'b1, "R8 empty irq level", empty_irq, 1);

      // R1 plain 8-bit frame
      sb.push_back(mk({1'b0, 8'h5A}, 8, 2'b00, 0, 0, "R1 8N1 frame"));
      wr(8'h5A);
      chk(empty_flag == 1'b0, "R6 flag low after write", empty_flag, 0);
      chk(empty_irq == 1'b0, "R8 empty irq drops", empty_irq, 0);
      wait_done();
      chk(done_flag == 1'b1, "R9 done set", done_flag, 1);
      chk(done_irq == 1'b1, "R10 done irq level", done_irq, 1);
      repeat (3) @(negedge clk);
      chk(done_flag == 1'b1, "R9 done holds", done_flag, 1);
      pulse_clr(0);
      chk(done_flag == 1'b0, "R10 write-one clear", done_flag, 0);

      // R6 back-to-back hand-over
      sb.push_back(mk({1'b0, 8'hC1}, 8, 2'b00, 0, 0, "R6 first of pair"));
      sb.push_back(mk({1'b0, 8'h3E}, 8, 2'b00, 0, 1, "R6 second of pair"));
      wr(8'hC1);
      wait_empty();
      wr(8'h3E);
      wait_done();
      pulse_clr(1);
      chk(done_flag == 1'b0, "R10 ack clear", done_flag, 0);

      // R7 second write while full is ignored
      sb.push_back(mk({1'b0, 8'hA7}, 8, 2'b00, 0, 0, "R7 kept character"));
      wr(8'hA7);
      wr(8'h18);
      wait_done();
      pulse_clr(0);

      // R2/R4 five bits, even parity, upper bits ignored
      cfg(1, 0, 1, 1, 5, 2'b10, 0);
      sb.push_back(mk({1'b0, 8'hF3}, 5, 2'b10, 0, 0, "R2/R4 5E1 masked"));
      wr(8'hF3);
      wait_done();
      pulse_clr(0);

      // R2/R5 length below range clamps to five, two stops
      cfg(1, 0, 1, 1, 3, 2'b00, 1);
      sb.push_back(mk({1'b0, 8'hEA}, 5, 2'b00, 1, 0, "R2/R5 clamp low 2 stops"));
      wr(8'hEA);
      wait_done();
      pulse_clr(0);

      // R3/R4 nine bits, odd parity, bit9 changed after write
      cfg(1, 1, 1, 1, 9, 2'b11, 1);
      sb.push_back(mk({1'b1, 8'h81}, 9, 2'b11, 1, 0, "R3/R4 9O2 frame"));
      wr(8'h81);
      cfg(1, 0, 1, 1, 9, 2'b11, 1);
      wait_done();
      pulse_clr(0);

      // R2 length above range clamps to nine, even parity
      cfg(1, 0, 1, 1, 12, 2'b10, 0);
      sb.push_back(mk({1'b0, 8'hC3}, 9, 2'b10, 0, 0, "R2 clamp high 9E1"));
      wr(8'hC3);
      wait_done();
      pulse_clr(0);

      // R11 deferred disable
      cfg(1, 0, 1, 1, 8, 2'b00, 0);
      sb.push_back(mk({1'b0, 8'h96}, 8, 2'b00, 0, 0, "R11 drain first"));
      sb.push_back(mk({1'b0, 8'h69}, 8, 2'b00, 0, 1, "R11 drain second"));
      wr(8'h96);
      wait_empty();
      wr(8'h69);
      cfg(0, 0, 1, 1, 8, 2'b00, 0);
      chk(line_owned == 1'b1, "R11 still owned while draining", line_owned, 1);
      wait_done();
      @(negedge clk);
      chk(line_owned == 1'b0, "R11 released after drain", line_owned, 0);
      wr(8'h11);
      chk(empty_flag == 1'b1, "R11 write after release ignored", empty_flag, 1);
      repeat (150) @(negedge clk);
      chk(sb.size() == 0, "R6 all frames seen", sb.size(), 0);
      chk(txd == 1'b1, "R12 line high at end", txd, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule